// File: doc/BRIEF.md
# SDRAM Clock-Enable Power Manager

This block runs in the memory clock domain and owns the clock-enable pin of an external SDRAM. When automatic power-down is enabled and the memory interface has stayed idle for a programmed number of cycles, it drops the clock enable. The memory then sits in active power-down if some row is still open, or in precharge power-down if all banks are closed. As soon as the command queue holds work, it raises the clock enable again. It then holds off command issue for a programmed exit delay.

A self-refresh request from upstream parks the memory in self-refresh with the clock enable low. A minimum residency applies before the request may be released, and an exit delay applies after the pin rises. The self-refresh state lives in the memory-clock domain. A flag reports it upstream, so that a controller that has just been re-powered can boot into its low-power state instead of its configuration state. All state and outputs change on the falling edge of the memory clock, the same edge on which command outputs change.

Top module: `sdram_cke_ctrl`

## Requirements
- R1: While reset is held, `cke` is 0, `cmd_hold` is 1, `lp_mode` is 2'b00 and `sr_active` is 0. On the first falling edge after release, `cke` goes to 1 and `cmd_hold` goes to 0.
- R2: While `auto_pd_en` is 0, `cke` stays at 1 however long the interface is idle.
- R3: The interface counts as idle when `cmd_dly_done` is 1, `rdfifo_empty` is 1 and `cmd_fifo_nempty` is 0. Idle is first seen at falling edge e0. If idle holds and `auto_pd_en` is 1, `cke` falls on falling edge e0+N, where N is `pd_period` and a value of 0 acts as 1.
- R4: If idle is lost or `auto_pd_en` is cleared while the count runs, the count is abandoned and `cke` stays 1. The next idle period counts the full N cycles again.
- R5: At power-down entry, `lp_mode` becomes 2'b10 (active power-down) if `row_open` is 1 on the entry edge, and 2'b01 (precharge power-down) otherwise.
- R6: In either power-down mode, the first falling edge that sees `cmd_fifo_nempty` at 1 raises `cke` and returns `lp_mode` to 2'b00.
- R7: After a power-down exit, `cmd_hold` stays 1 for max(1, `exit_pd_dly`) cycles counted from the exit edge, and then drops to 0.
- R8: A `sr_req` seen in the idle or counting states enters self-refresh on that edge: `cke` goes to 0, `lp_mode` to 2'b11 and `sr_active` to 1. A `sr_req` seen during power-down is ignored.
- R9: Self-refresh is left only on an edge where `sr_req` is 0 and at least max(1, `sr_min_dly`) edges have passed since the entry edge.
- R10: On self-refresh exit, `cke` rises and `sr_active` clears. `cmd_hold` stays 1 for max(1, `sr_exit_dly`) cycles from the exit edge.
- R11: `cmd_hold` is 1 in every cycle in which `cke` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_pd_en | input | 1 | Enables automatic power-down |
| pd_period | input | DLY_W | Idle cycles before power-down entry |
| exit_pd_dly | input | DLY_W | Command hold-off after power-down exit |
| sr_min_dly | input | DLY_W | Minimum self-refresh residency |
| sr_exit_dly | input | DLY_W | Command hold-off after self-refresh exit |
| cmd_dly_done | input | 1 | All pending inter-command delays have expired |
| rdfifo_empty | input | 1 | Read data FIFO is empty |
| cmd_fifo_nempty | input | 1 | Command FIFO holds at least one command |
| row_open | input | 1 | At least one bank has an open row |
| sr_req | input | 1 | Level request for self-refresh |
| cke | output | 1 | Clock enable to the memory devices |
| cmd_hold | output | 1 | Blocks command issue while high |
| lp_mode | output | 2 | 00 none, 01 precharge PD, 10 active PD, 11 self-refresh |
| sr_active | output | 1 | Upstream flag: memory is in self-refresh |

## Verification
The bench drives inputs just after a rising edge, so the following falling edge is the first edge that sees them. A single registered transition therefore appears at the next rising edge. Power-down entry is due N+1 rising edges after the idle pattern is driven. Each hold-off ends max(1, D)+1 rising edges after the wake stimulus, and self-refresh exit follows the same arithmetic with the residency count. Each timed check samples one edge before and one edge after the predicted change, which pins the count to the exact cycle.

// File: rtl/cke_ctrl_pkg.sv
package cke_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_PD_ACT,
        ST_PD_PRE,
        ST_PD_EXIT,
        ST_SR,
        ST_SR_EXIT
    } cke_state_e;

    typedef enum logic [1:0] {
        LP_NONE = 2'b00,
        LP_PRE  = 2'b01,
        LP_ACT  = 2'b10,
        LP_SELF = 2'b11
    } lp_mode_e;

    typedef struct packed {
        cke_state_e state;
        logic       cke;
        logic       hold;
        lp_mode_e   mode;
        logic       sr_flag;
    } cke_regs_t;

endpackage

// File: rtl/cke_idle_detect.sv
module cke_idle_detect (
    input  logic cmd_dly_done,
    input  logic rdfifo_empty,
    input  logic cmd_fifo_nempty,
    output logic if_idle,
    output logic wake
);
    // Idle needs every outstanding delay expired, no read data in flight
    // and nothing queued; any queued command is a wake-up event.
    always_comb begin
        wake    = cmd_fifo_nempty;
        if_idle = cmd_dly_done && rdfifo_empty && !cmd_fifo_nempty;
    end
endmodule

// File: rtl/cke_dly_counter.sv
module cke_dly_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // A loaded value of 0 or 1 both expire on the first edge after loading.
    assign done = (cnt_q <= ONE);
endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl
    import cke_ctrl_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_pd_en,
    input  logic [DLY_W-1:0] pd_period,
    input  logic [DLY_W-1:0] exit_pd_dly,
    input  logic [DLY_W-1:0] sr_min_dly,
    input  logic [DLY_W-1:0] sr_exit_dly,
    input  logic             cmd_dly_done,
    input  logic             rdfifo_empty,
    input  logic             cmd_fifo_nempty,
    input  logic             row_open,
    input  logic             sr_req,
    output logic             cke,
    output logic             cmd_hold,
    output logic [1:0]       lp_mode,
    output logic             sr_active
);
    localparam cke_regs_t RESET_REGS = '{
        state:   ST_IDLE,
        cke:     1'b0,
        hold:    1'b1,
        mode:    LP_NONE,
        sr_flag: 1'b0
    };

    cke_regs_t        r_d, r_q;
    logic             if_idle, wake;
    logic             ld, cnt_done;
    logic [DLY_W-1:0] ld_val;

    cke_idle_detect u_idle (
        .cmd_dly_done    (cmd_dly_done),
        .rdfifo_empty    (rdfifo_empty),
        .cmd_fifo_nempty (cmd_fifo_nempty),
        .if_idle         (if_idle),
        .wake            (wake)
    );

    cke_dly_counter #(.W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (cnt_done)
    );

    always_comb begin
        r_d    = r_q;
        ld     = 1'b0;
        ld_val = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (sr_req) begin
                    r_d.state = ST_SR;
                    ld        = 1'b1;
                    ld_val    = sr_min_dly;
                end else if (auto_pd_en && if_idle) begin
                    r_d.state = ST_COUNT;
                    ld        = 1'b1;
                    ld_val    = pd_period;
                end
            end
            ST_COUNT: begin
                if (sr_req) begin
                    r_d.state = ST_SR;
                    ld        = 1'b1;
                    ld_val    = sr_min_dly;
                end else if (!auto_pd_en || !if_idle) begin
                    r_d.state = ST_IDLE;
                end else if (cnt_done) begin
                    r_d.state = row_open ? ST_PD_ACT : ST_PD_PRE;
                end
            end
            ST_PD_ACT, ST_PD_PRE: begin
                if (wake) begin
                    r_d.state = ST_PD_EXIT;
                    ld        = 1'b1;
                    ld_val    = exit_pd_dly;
                end
            end
            ST_PD_EXIT: begin
                if (cnt_done) r_d.state = ST_IDLE;
            end
            ST_SR: begin
                if (!sr_req && cnt_done) begin
                    r_d.state = ST_SR_EXIT;
                    ld        = 1'b1;
                    ld_val    = sr_exit_dly;
                end
            end
            ST_SR_EXIT: begin
                if (cnt_done) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase

        // Outputs are registered copies of what the next state implies.
        r_d.cke     = 1'b1;
        r_d.hold    = 1'b1;
        r_d.mode    = LP_NONE;
        r_d.sr_flag = 1'b0;
        unique case (r_d.state)
            ST_IDLE, ST_COUNT: r_d.hold = 1'b0;
            ST_PD_ACT: begin
                r_d.cke  = 1'b0;
                r_d.mode = LP_ACT;
            end
            ST_PD_PRE: begin
                r_d.cke  = 1'b0;
                r_d.mode = LP_PRE;
            end
            ST_SR: begin
                r_d.cke     = 1'b0;
                r_d.mode    = LP_SELF;
                r_d.sr_flag = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    assign cke       = r_q.cke;
    assign cmd_hold  = r_q.hold;
    assign lp_mode   = r_q.mode;
    assign sr_active = r_q.sr_flag;
endmodule

// File: rtl/sdram_cke_ctrl_checker.sv
module sdram_cke_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       auto_pd_en,
    input logic       cmd_dly_done,
    input logic       rdfifo_empty,
    input logic       cmd_fifo_nempty,
    input logic       row_open,
    input logic       cke,
    input logic       cmd_hold,
    input logic [1:0] lp_mode,
    input logic       sr_active
);
    p_enable_gate_r2: assert property (@(negedge clk) disable iff (!rst_n)
        ($fell(cke) && lp_mode != 2'b11) |-> $past(auto_pd_en));

    p_idle_entry_r3: assert property (@(negedge clk) disable iff (!rst_n)
        ($fell(cke) && lp_mode != 2'b11)
            |-> $past(cmd_dly_done && rdfifo_empty && !cmd_fifo_nempty));

    p_row_mode_r5: assert property (@(negedge clk) disable iff (!rst_n)
        ($fell(cke) && lp_mode == 2'b10) |-> $past(row_open));

    p_wake_r6: assert property (@(negedge clk) disable iff (!rst_n)
        ((lp_mode == 2'b01 || lp_mode == 2'b10) && cmd_fifo_nempty)
            |=> (cke && lp_mode == 2'b00));

    p_exit_hold_r7: assert property (@(negedge clk) disable iff (!rst_n)
        ($rose(cke) && $past(lp_mode) != 2'b00) |-> cmd_hold);

    p_sr_flag_r8: assert property (@(negedge clk) disable iff (!rst_n)
        sr_active |-> (!cke && lp_mode == 2'b11));

    p_hold_low_cke_r11: assert property (@(negedge clk) disable iff (!rst_n)
        !cke |-> cmd_hold);
endmodule

bind sdram_cke_ctrl sdram_cke_ctrl_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .auto_pd_en      (auto_pd_en),
    .cmd_dly_done    (cmd_dly_done),
    .rdfifo_empty    (rdfifo_empty),
    .cmd_fifo_nempty (cmd_fifo_nempty),
    .row_open        (row_open),
    .cke             (cke),
    .cmd_hold        (cmd_hold),
    .lp_mode         (lp_mode),
    .sr_active       (sr_active)
);

// File: tb/sdram_cke_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_cke_ctrl_bench;
    localparam int DLY_W = 8;
    localparam int WD_CYCLES = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             auto_pd_en = 1'b0;
    logic [DLY_W-1:0] pd_period = '0;
    logic [DLY_W-1:0] exit_pd_dly = '0;
    logic [DLY_W-1:0] sr_min_dly = '0;
    logic [DLY_W-1:0] sr_exit_dly = '0;
    logic             cmd_dly_done = 1'b0;
    logic             rdfifo_empty = 1'b1;
    logic             cmd_fifo_nempty = 1'b0;
    logic             row_open = 1'b0;
    logic             sr_req = 1'b0;
    logic             cke, cmd_hold, sr_active;
    logic [1:0]       lp_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdram_cke_ctrl #(.DLY_W(DLY_W)) u_sdram_cke_ctrl (
        .clk (clk), .rst_n (rst_n), .auto_pd_en (auto_pd_en),
        .pd_period (pd_period), .exit_pd_dly (exit_pd_dly),
        .sr_min_dly (sr_min_dly), .sr_exit_dly (sr_exit_dly),
        .cmd_dly_done (cmd_dly_done), .rdfifo_empty (rdfifo_empty),
        .cmd_fifo_nempty (cmd_fifo_nempty), .row_open (row_open),
        .sr_req (sr_req), .cke (cke), .cmd_hold (cmd_hold),
        .lp_mode (lp_mode), .sr_active (sr_active)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic go_busy();
        cmd_dly_done    = 1'b0;
        cmd_fifo_nempty = 1'b0;
        rdfifo_empty    = 1'b1;
    endtask

    task automatic go_idle();
        cmd_dly_done    = 1'b1;
        rdfifo_empty    = 1'b1;
        cmd_fifo_nempty = 1'b0;
    endtask

    // Idle driven at the current edge; cke must fall exactly n edges later + 1.
    task automatic expect_entry(input int n, input string req);
        go_idle();
        step(n);
        chk(req, "cke one edge before entry", int'(cke), 1);
        step(1);
        chk(req, "cke after count", int'(cke), 0);
    endtask

    task automatic wake_and_hold(input int d, input string req);
        cmd_fifo_nempty = 1'b1;
        step(1);
        chk("R6", "cke after wake", int'(cke), 1);
        chk("R6", "lp_mode after wake", int'(lp_mode), 0);
        step(d - 1);
        chk(req, "hold last cycle", int'(cmd_hold), 1);
        step(1);
        chk(req, "hold released", int'(cmd_hold), 0);
        go_busy();
        step(2);
    endtask

    task automatic t_reset();
        step(3);
        chk("R1", "cke in reset", int'(cke), 0);
        chk("R1", "hold in reset", int'(cmd_hold), 1);
        chk("R1", "lp_mode in reset", int'(lp_mode), 0);
        chk("R1", "sr_active in reset", int'(sr_active), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "cke after first edge", int'(cke), 1);
        chk("R1", "hold after first edge", int'(cmd_hold), 0);
    endtask

    task automatic t_disabled();
        bit stayed_high = 1'b1;
        auto_pd_en = 1'b0;
        pd_period  = 8'd2;
        go_idle();
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (!cke) stayed_high = 1'b0;
        end
        chk("R2", "cke held while disabled", int'(stayed_high), 1);
        go_busy();
        auto_pd_en = 1'b1;
        step(2);
    endtask

    task automatic t_precharge_pd();
        pd_period   = 8'd6;
        exit_pd_dly = 8'd4;
        row_open    = 1'b0;
        expect_entry(6, "R3");
        chk("R5", "precharge mode", int'(lp_mode), 1);
        chk("R11", "hold while cke low", int'(cmd_hold), 1);
        // Self-refresh request during power-down must be ignored.
        sr_req = 1'b1;
        step(3);
        chk("R8", "mode kept in PD with sr_req", int'(lp_mode), 1);
        chk("R8", "no sr flag in PD", int'(sr_active), 0);
        sr_req = 1'b0;
        step(1);
        wake_and_hold(4, "R7");
    endtask

    task automatic t_active_pd();
        pd_period   = 8'd3;
        exit_pd_dly = 8'd2;
        row_open    = 1'b1;
        expect_entry(3, "R3");
        chk("R5", "active mode", int'(lp_mode), 2);
        row_open = 1'b0;
        wake_and_hold(2, "R7");
    endtask

    task automatic t_restart();
        pd_period   = 8'd6;
        exit_pd_dly = 8'd3;
        go_idle();
        step(3);
        rdfifo_empty = 1'b0;
        step(1);
        chk("R4", "cke after idle lost", int'(cke), 1);
        expect_entry(6, "R4");
        wake_and_hold(3, "R7");
        go_idle();
        step(3);
        auto_pd_en = 1'b0;
        step(1);
        auto_pd_en = 1'b1;
        expect_entry(6, "R4");
        wake_and_hold(3, "R7");
    endtask

    task automatic t_zero_period();
        pd_period   = 8'd0;
        exit_pd_dly = 8'd2;
        expect_entry(1, "R3");
        wake_and_hold(2, "R7");
    endtask

    task automatic t_sr_min();
        sr_min_dly  = 8'd5;
        sr_exit_dly = 8'd3;
        go_busy();
        sr_req = 1'b1;
        step(1);
        chk("R8", "cke in SR", int'(cke), 0);
        chk("R8", "lp_mode in SR", int'(lp_mode), 3);
        chk("R8", "sr_active in SR", int'(sr_active), 1);
        chk("R11", "hold in SR", int'(cmd_hold), 1);
        sr_req = 1'b0;
        step(4);
        chk("R9", "still SR before residency", int'(cke), 0);
        step(1);
        chk("R10", "cke after SR exit", int'(cke), 1);
        chk("R10", "sr_active after exit", int'(sr_active), 0);
        step(2);
        chk("R10", "hold last cycle", int'(cmd_hold), 1);
        step(1);
        chk("R10", "hold released", int'(cmd_hold), 0);
        step(2);
    endtask

    task automatic t_sr_level();
        sr_min_dly  = 8'd3;
        sr_exit_dly = 8'd2;
        pd_period   = 8'd8;
        go_idle();
        step(2);
        sr_req = 1'b1;
        step(1);
        chk("R8", "SR entered from counting", int'(lp_mode), 3);
        go_busy();
        step(5);
        chk("R9", "SR held while requested", int'(sr_active), 1);
        sr_req = 1'b0;
        step(1);
        chk("R9", "SR left after release", int'(cke), 1);
        step(1);
        chk("R10", "hold second cycle", int'(cmd_hold), 1);
        step(1);
        chk("R10", "hold released", int'(cmd_hold), 0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_precharge_pd();
        t_active_pd();
        t_restart();
        t_zero_period();
        t_sr_min();
        t_sr_level();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule